// File: doc/BRIEF.md
# Registered Command Buffer with Parity Check

This block sits between a memory controller and the devices of a two-rank memory module. On each rising clock edge it captures the command and address bus: row/column address, bank address, the three active-low command strobes, and one chip select, one clock enable and one termination enable for each rank. It drives the captured values to the memory devices for the whole of the following cycle. The buffer therefore adds exactly one cycle of latency and isolates the controller from the load of many device inputs.

The controller may also supply an even-parity bit that covers the address and the three command strobes. In every cycle where at least one rank is selected, the buffer checks that bit. It pulls an active-low error flag low in the same cycle in which the failing command appears on its outputs. The flag models an open-drain pin: a low value means driven, a high value means released.

An asynchronous active-low reset clears every registered bus output at once, without waiting for a clock edge, and releases the error flag. A system that does not use parity can tie the parity input to a constant; the command pipeline then works exactly as before.

Top module: `cmdbuf_top`

## Requirements
- R1: Each of the address, bank and command strobe outputs equals the value present on its input at the previous rising clock edge, so there is exactly one cycle of latency.
- R2: A command is a parity failure when the XOR over all address bits, ras_n, cas_n, we_n and the parity input is 1, which is an odd count of ones. In that case err_n_o is 0 during the cycle after the edge that captured the command.
- R3: A command is checked only when at least one chip-select input bit is 0. When every chip select is 1 (deselect), err_n_o is 1 in the following cycle whatever the parity input is.
- R4: The error flag is low for exactly one cycle for each failing command. Back-to-back failing commands keep it low in each of their cycles, and the flag returns high after the first command that passes or is deselected.
- R5: While rst_n is 0, every bus output (addr_o, ba_o, ras_n_o, cas_n_o, we_n_o, cs_n_o, cke_o, odt_o) is 0. These outputs go to 0 within the same time step as the falling edge of rst_n, even in the middle of a clock cycle.
- R6: While rst_n is 0, err_n_o is released (1).
- R7: The per-rank controls are registered independently. Bit k of cs_n_o, cke_o and odt_o follows bit k of the matching input, with one cycle of latency, for each rank k (bit 0 is rank 0).
- R8: The value of the parity input never changes addr_o, ba_o, the command strobes or the rank controls. With the parity input tied to 0, the pipeline keeps its one-cycle behaviour.
- R9: All 16 address bits and all 3 bank bits pass through the buffer, including the all-ones and all-zeros patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Row/column address from the controller |
| ba_i | input | 3 | Bank address from the controller |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| cs_n_i | input | 2 | Chip select per rank, active low |
| cke_i | input | 2 | Clock enable per rank |
| odt_i | input | 2 | Termination enable per rank |
| par_i | input | 1 | Even-parity bit over address and strobes |
| addr_o | output | 16 | Registered address |
| ba_o | output | 3 | Registered bank address |
| ras_n_o | output | 1 | Registered row strobe |
| cas_n_o | output | 1 | Registered column strobe |
| we_n_o | output | 1 | Registered write enable |
| cs_n_o | output | 2 | Registered chip selects |
| cke_o | output | 2 | Registered clock enables |
| odt_o | output | 2 | Registered termination enables |
| err_n_o | output | 1 | Parity error, low = driven (open-drain model) |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of a cycle while the error flag is already low for a failing command. Only then does the forced release of the flag and the clearing of the outputs mean anything. The stimulus first registers a command with deliberately corrupted parity and checks that the flag is low. It then drops rst_n a few time units after the capturing edge, looks at the outputs one time unit later, and holds reset across a full edge before releasing it on a falling edge. Deselect cycles with bad parity, back-to-back failures, and a long stretch with the parity input tied to 0 are mixed into seeded random traffic.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
  localparam int unsigned DEF_ADDR_W = 16;
  localparam int unsigned DEF_BANK_W = 3;
  localparam int unsigned DEF_RANKS  = 2;

  // Per-rank control group, carried through one register stage together.
  typedef struct packed {
    logic cs_n;
    logic cke;
    logic odt;
  } rank_ctl_t;
endpackage

// File: rtl/cmdbuf_stage.sv
module cmdbuf_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/cmdbuf_parity.sv
module cmdbuf_parity #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned RANKS  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              par,
  input  logic [RANKS-1:0]  cs_n,
  output logic              fail
);
  localparam int unsigned CW = ADDR_W + 4;

  logic [CW-1:0] covered;
  logic [CW:0]   chain;
  logic          selected;

  assign covered  = {addr, ras_n, cas_n, we_n, par};
  assign chain[0] = 1'b0;

  for (genvar i = 0; i < CW; i++) begin : g_xor
    assign chain[i+1] = chain[i] ^ covered[i];
  end

  assign selected = ~&cs_n;
  assign fail     = selected & chain[CW];
endmodule

// File: rtl/cmdbuf_errflag.sv
module cmdbuf_errflag (
  input  logic clk,
  input  logic rst_n,
  input  logic fail,
  output logic err_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_n <= 1'b1;
    else        err_n <= ~fail;
  end

  // R6
  always @(posedge clk) begin
    if (!rst_n) begin
      err_released_chk: assert (err_n == 1'b1);
    end
  end
endmodule

// File: rtl/cmdbuf_top.sv
module cmdbuf_top
  import cmdbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned BANK_W = DEF_BANK_W,
  parameter int unsigned RANKS  = DEF_RANKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [RANKS-1:0]  cs_n_i,
  input  logic [RANKS-1:0]  cke_i,
  input  logic [RANKS-1:0]  odt_i,
  input  logic              par_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] ba_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [RANKS-1:0]  cs_n_o,
  output logic [RANKS-1:0]  cke_o,
  output logic [RANKS-1:0]  odt_o,
  output logic              err_n_o
);
  localparam int unsigned CMD_W  = ADDR_W + BANK_W + 3;
  localparam int unsigned RCTL_W = $bits(rank_ctl_t);

  logic [CMD_W-1:0] cmd_d, cmd_q;
  logic             parity_fail;

  assign cmd_d = {addr_i, ba_i, ras_n_i, cas_n_i, we_n_i};

  cmdbuf_stage #(.W(CMD_W)) u_cmd_stage (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (cmd_d),
    .q    (cmd_q)
  );

  assign {addr_o, ba_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;

  for (genvar k = 0; k < RANKS; k++) begin : g_rank
    rank_ctl_t ctl_d, ctl_q;
    assign ctl_d = '{cs_n: cs_n_i[k], cke: cke_i[k], odt: odt_i[k]};

    cmdbuf_stage #(.W(RCTL_W)) u_rank_stage (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (ctl_d),
      .q    (ctl_q)
    );

    assign cs_n_o[k] = ctl_q.cs_n;
    assign cke_o[k]  = ctl_q.cke;
    assign odt_o[k]  = ctl_q.odt;
  end

  cmdbuf_parity #(.ADDR_W(ADDR_W), .RANKS(RANKS)) u_parity (
    .addr (addr_i),
    .ras_n(ras_n_i),
    .cas_n(cas_n_i),
    .we_n (we_n_i),
    .par  (par_i),
    .cs_n (cs_n_i),
    .fail (parity_fail)
  );

  cmdbuf_errflag u_errflag (
    .clk  (clk),
    .rst_n(rst_n),
    .fail (parity_fail),
    .err_n(err_n_o)
  );

  // R1
  cmd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (addr_o == $past(addr_i)) && (ba_o == $past(ba_i)) &&
                     (ras_n_o == $past(ras_n_i)) && (cas_n_o == $past(cas_n_i)) &&
                     (we_n_o == $past(we_n_i)));

  // R7
  rank_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cs_n_o == $past(cs_n_i)) && (cke_o == $past(cke_i)) &&
                     (odt_o == $past(odt_i)));

  // R2
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(~&cs_n_i)) |->
      (err_n_o == ~$past(^{addr_i, ras_n_i, cas_n_i, we_n_i, par_i})));

  // R3
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(&cs_n_i)) |-> err_n_o);

  // R5
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert ((cmd_q == '0) && (cs_n_o == '0) && (cke_o == '0) && (odt_o == '0));
    end
  end
endmodule

// File: tb/cmdbuf_top_tb.sv
module cmdbuf_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int BW = 3;
  localparam int NR = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [BW-1:0] ba_i = '0;
  logic          ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
  logic [NR-1:0] cs_n_i = '1, cke_i = '0, odt_i = '0;
  logic          par_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic [BW-1:0] ba_o;
  logic          ras_n_o, cas_n_o, we_n_o;
  logic [NR-1:0] cs_n_o, cke_o, odt_o;
  logic          err_n_o;

  int checks = 0;
  int errors = 0;

  logic [AW+BW+2:0]  exp_cmd;
  logic [3*NR-1:0]   exp_rank;
  logic              exp_err_n;
  bit                have_exp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdbuf_top u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ba_i(ba_i),
    .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
    .cs_n_i(cs_n_i), .cke_i(cke_i), .odt_i(odt_i), .par_i(par_i),
    .addr_o(addr_o), .ba_o(ba_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .cs_n_o(cs_n_o), .cke_o(cke_o), .odt_o(odt_o),
    .err_n_o(err_n_o)
  );

  function automatic logic odd_ones(input logic [AW-1:0] a, input logic r,
                                    input logic c, input logic w, input logic p);
    int n = 0;
    for (int i = 0; i < AW; i++) n += int'(a[i]);
    n += int'(r) + int'(c) + int'(w) + int'(p);
    return (n % 2) == 1;
  endfunction

  function automatic logic good_par(input logic [AW-1:0] a, input logic r,
                                    input logic c, input logic w);
    return odd_ones(a, r, c, w, 1'b0);
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Compare the outputs with the previous step, then drive a new command.
  task automatic step(input logic [AW-1:0] a, input logic [BW-1:0] b,
                      input logic r, input logic c, input logic w,
                      input logic [NR-1:0] cs, input logic [NR-1:0] ke,
                      input logic [NR-1:0] od, input logic p, input string tag);
    @(negedge clk);
    if (have_exp) begin
      chk("R1 cmd", 64'({addr_o, ba_o, ras_n_o, cas_n_o, we_n_o}), 64'(exp_cmd));
      chk("R7 rank", 64'({cs_n_o, cke_o, odt_o}), 64'(exp_rank));
      chk(tag, 64'(err_n_o), 64'(exp_err_n));
    end
    addr_i = a; ba_i = b; ras_n_i = r; cas_n_i = c; we_n_i = w;
    cs_n_i = cs; cke_i = ke; odt_i = od; par_i = p;
    exp_cmd   = {a, b, r, c, w};
    exp_rank  = {cs, ke, od};
    exp_err_n = (&cs) ? 1'b1 : ~odd_ones(a, r, c, w, p);
    have_exp  = 1;
  endtask

  task automatic rand_step(input bit tie_par, input string tag);
    logic [AW-1:0] a  = AW'($urandom());
    logic [BW-1:0] b  = BW'($urandom());
    logic [2:0]    s  = 3'($urandom());
    logic [NR-1:0] cs = NR'($urandom());
    logic [NR-1:0] ke = NR'($urandom());
    logic [NR-1:0] od = NR'($urandom());
    logic          p  = good_par(a, s[2], s[1], s[0]);
    if (($urandom() % 4) == 0) p = ~p;
    if (tie_par) p = 1'b0;
    step(a, b, s[2], s[1], s[0], cs, ke, od, p, tag);
  endtask

  task automatic check_all_low(input string tag);
    chk(tag, 64'({addr_o, ba_o, ras_n_o, cas_n_o, we_n_o, cs_n_o, cke_o, odt_o}), 64'd0);
    chk("R6 err released", 64'(err_n_o), 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #2 rst_n = 1'b0;
    #1 check_all_low("R5 reset state");
    @(negedge clk); @(negedge clk);
    check_all_low("R5 reset held");
    rst_n = 1'b1;

    // R9: full-width patterns, good parity
    step('1, '1, 1'b0, 1'b0, 1'b0, 2'b10, 2'b11, 2'b11, good_par('1, 0, 0, 0), "R2 ones good");
    step('0, '0, 1'b1, 1'b1, 1'b1, 2'b01, 2'b00, 2'b00, good_par('0, 1, 1, 1), "R9 zeros good");
    // R2: corrupted parity, both ranks selected
    step(16'hA5C3, 3'b101, 1'b0, 1'b1, 1'b0, 2'b00, 2'b10, 2'b01,
         ~good_par(16'hA5C3, 0, 1, 0), "R9 pattern bad");
    // R4: back-to-back failures then a pass
    step(16'h0001, 3'b010, 1'b1, 1'b0, 1'b1, 2'b10, 2'b01, 2'b10,
         ~good_par(16'h0001, 1, 0, 1), "R4 first fail");
    step(16'h8000, 3'b001, 1'b1, 1'b1, 1'b0, 2'b01, 2'b01, 2'b10,
         ~good_par(16'h8000, 1, 1, 0), "R4 second fail");
    step(16'h1234, 3'b110, 1'b0, 1'b1, 1'b1, 2'b10, 2'b00, 2'b01,
         good_par(16'h1234, 0, 1, 1), "R4 back-to-back");
    // R3: deselect with bad parity
    step(16'hFFFE, 3'b011, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11, 2'b00,
         ~good_par(16'hFFFE, 0, 0, 1), "R4 pass after fail");
    step(16'h7777, 3'b100, 1'b1, 1'b0, 1'b0, 2'b11, 2'b10, 2'b11,
         ~good_par(16'h7777, 1, 0, 0), "R3 deselect bad");
    step(16'h0F0F, 3'b000, 1'b0, 1'b0, 1'b0, 2'b10, 2'b01, 2'b00,
         good_par(16'h0F0F, 0, 0, 0), "R3 deselect bad");

    for (int i = 0; i < 300; i++) rand_step(1'b0, "R2 random parity");

    // R5/R6: mid-cycle reset while a failing command is on the outputs
    step(16'hC0DE, 3'b111, 1'b0, 1'b1, 1'b0, 2'b01, 2'b11, 2'b11,
         ~good_par(16'hC0DE, 0, 1, 0), "R2 before reset");
    #(CLK_PERIOD/2 + 2);
    chk("R2 flag low before reset", 64'(err_n_o), 64'd0);
    rst_n = 1'b0;
    #1 check_all_low("R5 mid-cycle reset");
    @(negedge clk); @(negedge clk);
    check_all_low("R5 reset across edge");
    rst_n = 1'b1;
    // The same command is still driven and is recaptured after release.

    for (int i = 0; i < 200; i++) rand_step(1'b1, "R8 parity tied low");
    for (int i = 0; i < 100; i++) rand_step(1'b0, "R3 random mix");
    step('0, '0, 1'b1, 1'b1, 1'b1, 2'b11, 2'b00, 2'b00, 1'b0, "R3 idle");
    step('0, '0, 1'b1, 1'b1, 1'b1, 2'b11, 2'b00, 2'b00, 1'b0, "R3 idle");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule